// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block turns a fast system clock into the timing grid an I2C master needs to drive SCL. An 8-bit rate word sets the division. A 4-bit linear field `M` and a 3-bit exponent field `N` give a base tick period of `(M+1) * 2^(N+1)` system clocks. Ten base ticks make one SCL period, so the bus runs at `f_clk / (10 * (M+1) * 2^(N+1))`.

The divider has two stages. A prescaler counts `M+1` clocks, and a power-of-two counter counts `2^(N+1)` prescaler wraps to form the base tick. A decimal phase counter then walks the ten ticks of each SCL period. From it the block derives the SCL level and a mid-high sample strobe for the bit engine.

Each write of the rate word clears all three counters, so the new rate starts from a clean period boundary. After reset the word is zero, which selects the fastest setting (two clocks per tick).

Top module: `scl_rate_gen`

## Requirements
- R1: While and directly after reset, the rate word is 0, and `tick_o`, `scl_o` and `sample_o` are all low.
- R2: With a stored setting, consecutive `tick_o` pulses are exactly `(M+1) * 2^(N+1)` clocks apart, and each pulse lasts one clock.
- R3: The rate word is decoded as follows: `M` = `baud_wdata_i[6:3]`, `N` = `baud_wdata_i[2:0]`, and bit 7 has no effect on the rate.
- R4: A write restarts the divider. The first `tick_o` after a write appears in the P-th clock cycle that follows the write edge, where P is the new tick period.
- R5: A write in a cycle where `tick_o` would otherwise pulse suppresses that pulse.
- R6: Each SCL period is 10 ticks long. `scl_o` is low for the first 5 ticks and high for the last 5, so the high time is 5P clocks.
- R7: `sample_o` pulses once per SCL period, only while `scl_o` is high. It coincides with the tick that ends the third high tick, which falls 3P clocks after SCL rises.
- R8: The slowest setting (`M`=15, `N`=7) gives a tick period of 4096 clocks and an SCL high time of 20480 clocks.
- R9: After a write, `scl_o` is low in the next cycle, whatever phase the divider was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_we_i | input | 1 | Rate word write strobe |
| baud_wdata_i | input | 8 | Rate word: M in [6:3], N in [2:0], bit 7 unused |
| tick_o | output | 1 | Base tick strobe, one per (M+1)*2^(N+1) clocks |
| scl_o | output | 1 | SCL level: low in phases 0-4, high in phases 5-9 |
| sample_o | output | 1 | SDA sample strobe at the middle of the high phase |

## Verification
A rate write and a terminal tick can fall in the same cycle. The write must win: the tick is masked and every counter restarts from zero.

The bench provokes this at the fastest rate. It waits until `tick_o` is observed high and raises the write strobe inside that same cycle. It then confirms that `tick_o` drops at once and that the next tick arrives exactly one full period after the write edge, with no extra or shortened tick.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int unsigned M_W   = 4;
  localparam int unsigned N_W   = 3;
  localparam int unsigned POW_W = 1 << N_W;  // widest power stage: 2^(2^N_W)

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } rate_t;
endpackage

// File: rtl/rate_reg.sv
module rate_reg
  import scl_rate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output rate_t      rate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rate_o <= '0;
    else if (we_i) rate_o <= rate_t'(wdata_i[M_W+N_W-1:0]);
  end

  AST_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rate_o)); // R3
endmodule

// File: rtl/prescale_ctr.sv
module prescale_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q <= lim_i); // R2
endmodule

// File: rtl/pow2_ctr.sv
module pow2_ctr #(
  parameter int unsigned EXP_W = 3,
  parameter int unsigned W     = 1 << EXP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             done_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   span;
  logic [W-1:0] lim;

  // 2^(exp+1) steps per wrap; widened so exp = max does not overflow
  always_comb begin
    span = (W+1)'(1) << ({1'b0, exp_i} + 1'b1);
    lim  = span[W-1:0] - 1'b1;
  end

  assign done_o = step_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_POW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int unsigned PHASES     = 10,
  parameter int unsigned HIGH_START = 5,
  parameter int unsigned SAMPLE_PH  = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_we_i,
  input  logic [7:0] baud_wdata_i,
  output logic       tick_o,
  output logic       scl_o,
  output logic       sample_o
);
  localparam int unsigned PH_W = $clog2(PHASES);

  rate_t           rate;
  logic            pre_wrap;
  logic            pow_done;
  logic [PH_W-1:0] phase_q;

  rate_reg u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (baud_we_i),
    .wdata_i (baud_wdata_i),
    .rate_o  (rate)
  );

  prescale_ctr #(.W(M_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (baud_we_i),
    .lim_i  (rate.m),
    .wrap_o (pre_wrap)
  );

  pow2_ctr #(.EXP_W(N_W), .W(POW_W)) u_pow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (baud_we_i),
    .step_i (pre_wrap),
    .exp_i  (rate.n),
    .done_o (pow_done)
  );

  // a write wins over a coinciding terminal count
  assign tick_o = pow_done && !baud_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (baud_we_i) phase_q <= '0;
    else if (tick_o)    phase_q <= (phase_q == PH_W'(PHASES-1)) ? '0 : phase_q + 1'b1;
  end

  assign scl_o    = (phase_q >= PH_W'(HIGH_START));
  assign sample_o = tick_o && (phase_q == PH_W'(SAMPLE_PH));

  AST_TICK_FROM_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> pre_wrap); // R2
  AST_WR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_we_i |=> !scl_o); // R9
  AST_SCL_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !baud_we_i) |=> $stable(scl_o)); // R6
  AST_SAMPLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> scl_o); // R7
  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PH_W'(PHASES)); // R6
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  localparam int NV = 7;
  localparam logic [7:0] VEC_W [NV] = '{8'h00, 8'h08, 8'h03, 8'h2A, 8'h85, 8'h79, 8'hFF};
  localparam int         VEC_P [NV] = '{2, 4, 16, 48, 64, 64, 4096};
  localparam int WD_CYC = 190000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_we_i = 1'b0;
  logic [7:0] baud_wdata_i = '0;
  logic       tick_o, scl_o, sample_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  scl_rate_gen i_scl_rate_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_we_i(baud_we_i),
    .baud_wdata_i(baud_wdata_i), .tick_o(tick_o), .scl_o(scl_o), .sample_o(sample_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // write, then count cycles until the first tick (1 = cycle right after write edge)
  task automatic write_first(input logic [7:0] d, output int n);
    @(negedge clk_i); baud_we_i = 1'b1; baud_wdata_i = d;
    @(negedge clk_i); baud_we_i = 1'b0; #1;
    n = 1;
    while (!tick_o && n < 10000) begin @(negedge clk_i); #1; n++; end
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin @(negedge clk_i); #1; n++; end while (!tick_o && n < 10000);
  endtask

  initial begin
    int n;
    #1;
    chk("R1 tick in reset", tick_o, 0);
    chk("R1 scl in reset", scl_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; #1;
    chk("R1 sample after reset", sample_o, 0);
    chk("R1 scl after reset", scl_o, 0);
    // R1: word is 0 -> fastest rate
    next_tick(n);
    next_tick(n);
    chk("R1 default period", n, 2);

    // R2/R3/R4/R8 vector table
    for (int i = 0; i < NV; i++) begin
      write_first(VEC_W[i], n);
      chk($sformatf("R4 first tick w=%02h", VEC_W[i]), n, VEC_P[i]);
      next_tick(n);
      chk($sformatf("R2 R3 interval w=%02h", VEC_W[i]), n, VEC_P[i]);
    end

    // R5: write coinciding with a tick masks it
    write_first(8'h00, n);
    @(negedge clk_i); #1;
    while (!tick_o) begin @(negedge clk_i); #1; end
    baud_we_i = 1'b1; baud_wdata_i = 8'h00; #1;
    chk("R5 tick masked", tick_o, 0);
    @(negedge clk_i); baud_we_i = 1'b0; #1;
    n = 1;
    while (!tick_o && n < 100) begin @(negedge clk_i); #1; n++; end
    chk("R5 restart after masked tick", n, 2);

    // R6/R7 at P=4
    write_first(8'h08, n);
    while (scl_o) begin @(negedge clk_i); #1; end
    while (!scl_o) begin @(negedge clk_i); #1; end
    begin
      int hi = 0, samp_at = -1, samp_cnt = 0, lo = 0;
      while (scl_o) begin
        hi++;
        if (sample_o) begin samp_cnt++; samp_at = hi; end
        @(negedge clk_i); #1;
      end
      while (!scl_o) begin
        lo++;
        if (sample_o) samp_cnt++;
        @(negedge clk_i); #1;
      end
      chk("R6 high time", hi, 20);
      chk("R6 low time", lo, 20);
      chk("R7 sample count", samp_cnt, 1);
      chk("R7 sample position", samp_at, 12);
    end

    // R9: write while high forces low
    while (!scl_o) begin @(negedge clk_i); #1; end
    baud_we_i = 1'b1; baud_wdata_i = 8'h08;
    @(negedge clk_i); baud_we_i = 1'b0; #1;
    chk("R9 scl low after write", scl_o, 0);

    // R8: slowest high time
    write_first(8'hFF, n);
    while (!scl_o) begin @(negedge clk_i); #1; end
    n = 0;
    while (scl_o && n < 30000) begin @(negedge clk_i); #1; n++; end
    chk("R8 slowest high time", n, 20480);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule